// File: doc/BRIEF.md
# Inbound Read Abort Response Controller

This block sits between the memory-side return path of inbound reads and the host-bus target logic. Returned data arrives as 64-bit qwords, each with a two-bit abort flag, one bit for each 32-bit half. The block queues the qwords and hands them to the host one dword at a time. An uncorrectable ECC error on the memory side reaches it as an internal target abort, and the block turns that abort into the host-bus response that the current bus mode calls for.

In conventional mode nothing happens until the host actually reaches an aborted word. At that word the block answers with either a target abort or a disconnect-with-data, selected by an enable input. It then discards the rest of the transaction and flushes the queue when the host cycle completes. In split-transaction mode an aborted qword causes a split-completion error message descriptor, which is held on a valid/ready handshake. A sticky status bit and sticky interrupt-status bits record these events. The interrupt-status bits are gated by mask inputs, and all of them are cleared by write-1-to-clear.

Top module: `rd_abort_ctrl`

## Requirements
- R1: Abort tracking is per qword. A nonzero `ret_abort_i` (2'b01, 2'b10 or 2'b11) marks both dwords of that qword as aborted, so the first dword the host reads from it already takes the abort response.
- R2: In conventional mode (mode_i=0 at rd_start_i) with `ecc_ta_en_i`=1, a host request that reaches an aborted dword produces `host_ta_o`=1 one cycle later, with `host_ack_o`=0.
- R3: In conventional mode with `ecc_ta_en_i`=0, that request instead produces `host_ack_o`=1 and `host_disc_o`=1, with the dword's data on `host_data_o`. `host_ta_o` and `host_disc_o` are never both high.
- R4: Clean dwords are delivered in order, each with `host_ack_o`=1 one cycle after `host_req_i`: the low half [31:0] of a qword first, then the high half [63:32]. Aborted qwords cause no response and no status change until the host requests them.
- R5: After an abort response, further host requests get no ack, target abort or disconnect. `cyc_done_i` then flushes the queue, so a following read transaction starts empty.
- R6: Bit 11 of `status_o` is set when a target abort is returned to the host. A disconnect-with-data does not set it.
- R7: Bit 0 of `isr_o` is set along with a target abort only when `ta_mask_i`=0.
- R8: In split mode (mode_i=1 at rd_start_i), an aborted returned qword raises `scem_valid_o` one cycle after acceptance, with class 4'h2 and index 8'h81. The descriptor is held until `scem_ready_i`, and the queue is then flushed.
- R9: Bit 1 of `isr_o` is set when the message is launched, only when `scem_mask_i`=0.
- R10: Writing 1 clears a bit: `reg_sel_i`=0 selects the status register and `reg_sel_i`=1 the interrupt-status register. A hardware set in the same cycle wins over the clear.
- R11: The mode is sampled at `rd_start_i` and held for the whole transaction. A change of `mode_i` in the middle of a transaction has no effect.
- R12: After reset all responses, `scem_valid_o`, `status_o` and `isr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_start_i | input | 1 | Start of an inbound read transaction |
| mode_i | input | 1 | 0 conventional, 1 split-transaction |
| ecc_ta_en_i | input | 1 | Answer an aborted word with a target abort instead of a disconnect |
| ta_mask_i | input | 1 | Mask for the target-abort interrupt-status bit |
| scem_mask_i | input | 1 | Mask for the split-error interrupt-status bit |
| ret_valid_i | input | 1 | Returned qword valid |
| ret_ready_o | output | 1 | Queue can accept a qword |
| ret_abort_i | input | 2 | Abort flag, one bit per dword half |
| ret_data_i | input | 64 | Returned qword |
| host_req_i | input | 1 | Host requests the next dword |
| host_ack_o | output | 1 | Dword delivered |
| host_ta_o | output | 1 | Target abort to the host |
| host_disc_o | output | 1 | Disconnect with data |
| host_data_o | output | 32 | Delivered dword |
| cyc_done_i | input | 1 | Host bus cycle completed |
| scem_valid_o | output | 1 | Split-completion error descriptor valid |
| scem_ready_i | input | 1 | Descriptor accepted |
| scem_class_o | output | 4 | Message class |
| scem_index_o | output | 8 | Message index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 status, 1 interrupt status |
| reg_wdata_i | input | 16 | Write-1-to-clear data |
| status_o | output | 16 | Status register |
| isr_o | output | 8 | Interrupt-status register |

## Verification
The bench sweeps every combination of the abort-enable bit, the interrupt mask, the position of the aborted qword and the aborted half. This catches a design that tracks aborts per dword: given an abort only on the high half, such a design would deliver the low half as clean. The sweep also catches a design that reports the abort when the qword arrives rather than when the host reaches it, and one that sets the status bit on a disconnect. Directed runs check that the queue is empty after a flush, that a set wins over a same-cycle clear, that a mode change in mid-transaction is ignored, and that the split descriptor holds its fields while ready stays low.

// File: rtl/rd_abort_pkg.sv
package rd_abort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_SPLIT = 3'd2,
    ST_WAIT  = 3'd3,
    ST_MSG   = 3'd4
  } rd_state_e;

  localparam int STATUS_W  = 16;
  localparam int ISR_W     = 8;
  localparam int TA_STS_BIT = 11;
  localparam int ISR_TA_BIT = 0;
  localparam int ISR_SC_BIT = 1;
  localparam logic [3:0] SCEM_CLASS = 4'h2;
  localparam logic [7:0] SCEM_INDEX = 8'h81;
endpackage

// File: rtl/rd_qword_queue.sv
module rd_qword_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_abort_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              head_abort_o,
  output logic [DATA_W-1:0] head_data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  abort_q;
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;

  assign empty_o      = (cnt_q == '0);
  assign full_o       = (cnt_q == CW'(DEPTH));
  assign head_abort_o = abort_q[rd_ptr_q];
  assign head_data_o  = data_q[rd_ptr_q];

  function automatic logic [AW-1:0] inc_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        abort_q[g] <= 1'b0;
      end else if (push_i && !flush_i && wr_ptr_q == AW'(g)) begin
        data_q[g]  <= push_data_i;
        abort_q[g] <= push_abort_i;
      end
    end
  end

  p_no_push_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !flush_i |-> !full_o);
  p_no_pop_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !flush_i |-> !empty_o);
endmodule

// File: rtl/abort_stat_regs.sv
module abort_stat_regs
  import rd_abort_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_ta_i,
  input  logic                set_scem_i,
  input  logic                ta_mask_i,
  input  logic                scem_mask_i,
  input  logic                reg_wr_i,
  input  logic                reg_sel_i,
  input  logic [15:0]         reg_wdata_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [ISR_W-1:0]    isr_o
);
  logic sts_ta_q, isr_ta_q, isr_sc_q;
  logic clr_sts_ta, clr_isr_ta, clr_isr_sc;

  assign clr_sts_ta = reg_wr_i && !reg_sel_i && reg_wdata_i[TA_STS_BIT];
  assign clr_isr_ta = reg_wr_i &&  reg_sel_i && reg_wdata_i[ISR_TA_BIT];
  assign clr_isr_sc = reg_wr_i &&  reg_sel_i && reg_wdata_i[ISR_SC_BIT];

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_ta_q <= 1'b0;
      isr_ta_q <= 1'b0;
      isr_sc_q <= 1'b0;
    end else begin
      sts_ta_q <= set_ta_i || (sts_ta_q && !clr_sts_ta);
      isr_ta_q <= (set_ta_i && !ta_mask_i) || (isr_ta_q && !clr_isr_ta);
      isr_sc_q <= (set_scem_i && !scem_mask_i) || (isr_sc_q && !clr_isr_sc);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[TA_STS_BIT] = sts_ta_q;
    isr_o = '0;
    isr_o[ISR_TA_BIT] = isr_ta_q;
    isr_o[ISR_SC_BIT] = isr_sc_q;
  end

  p_ta_sets_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ta_i |=> status_o[TA_STS_BIT]);
  p_ta_isr_unmasked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ta_i && !ta_mask_i |=> isr_o[ISR_TA_BIT]);
  p_scem_isr_unmasked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_scem_i && !scem_mask_i |=> isr_o[ISR_SC_BIT]);
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sts_ta && !set_ta_i |=> !status_o[TA_STS_BIT]);
endmodule

// File: rtl/abort_resp_fsm.sv
module abort_resp_fsm
  import rd_abort_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  input  logic              mode_i,
  input  logic              ta_en_i,
  input  logic              ret_valid_i,
  input  logic [1:0]        ret_abort_i,
  input  logic              host_req_i,
  input  logic              cyc_done_i,
  input  logic              scem_ready_i,
  input  logic              q_empty_i,
  input  logic              q_full_i,
  input  logic              q_head_abort_i,
  input  logic [DATA_W-1:0] q_head_data_i,
  output logic              ret_ready_o,
  output logic              q_push_o,
  output logic              q_push_abort_o,
  output logic              q_pop_o,
  output logic              q_flush_o,
  output logic              host_ack_o,
  output logic              host_ta_o,
  output logic              host_disc_o,
  output logic [DATA_W/2-1:0] host_data_o,
  output logic              scem_valid_o,
  output logic              set_ta_o,
  output logic              set_scem_o
);
  localparam int HW = DATA_W / 2;

  rd_state_e st_q, st_d;
  logic half_q;
  logic active, ret_fire, split_abort, host_fire, abort_hit;
  logic ack_q, ta_q, disc_q;
  logic [HW-1:0] data_q;

  assign active      = (st_q == ST_CONV || st_q == ST_SPLIT) && !cyc_done_i;
  assign ret_ready_o = active && !q_full_i;
  assign ret_fire    = ret_valid_i && ret_ready_o;
  assign split_abort = ret_fire && (st_q == ST_SPLIT) && (|ret_abort_i);
  assign q_push_o    = ret_fire && !split_abort;
  assign q_push_abort_o = |ret_abort_i;  // qword granularity
  assign host_fire   = host_req_i && active && !q_empty_i;
  assign abort_hit   = host_fire && q_head_abort_i;
  assign q_pop_o     = host_fire && half_q && !abort_hit;
  assign q_flush_o   = ((st_q == ST_CONV || st_q == ST_SPLIT || st_q == ST_WAIT) && cyc_done_i)
                    || (st_q == ST_MSG && scem_ready_i);
  assign set_ta_o    = abort_hit && ta_en_i && (st_q == ST_CONV);
  assign set_scem_o  = split_abort;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (rd_start_i) st_d = mode_i ? ST_SPLIT : ST_CONV;
      ST_CONV:  if (cyc_done_i) st_d = ST_IDLE;
                else if (abort_hit) st_d = ST_WAIT;
      ST_SPLIT: if (cyc_done_i) st_d = ST_IDLE;
                else if (split_abort) st_d = ST_MSG;
      ST_WAIT:  if (cyc_done_i) st_d = ST_IDLE;
      ST_MSG:   if (scem_ready_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      ack_q  <= 1'b0;
      ta_q   <= 1'b0;
      disc_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      ack_q  <= host_fire && !set_ta_o;
      ta_q   <= set_ta_o;
      disc_q <= abort_hit && !set_ta_o;
      if (host_fire) data_q <= half_q ? q_head_data_i[DATA_W-1:HW] : q_head_data_i[HW-1:0];
      if (st_q == ST_IDLE) half_q <= 1'b0;
      else if (host_fire && !abort_hit) half_q <= !half_q;
    end
  end

  assign host_ack_o   = ack_q;
  assign host_ta_o    = ta_q;
  assign host_disc_o  = disc_q;
  assign host_data_o  = data_q;
  assign scem_valid_o = (st_q == ST_MSG);

  p_ta_disc_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_ta_o && host_disc_o));
  p_ta_no_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ta_o |-> !host_ack_o);
  p_silent_after_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT |=> !host_ack_o && !host_ta_o && !host_disc_o);
  p_msg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scem_valid_o && !scem_ready_i |=> scem_valid_o);
  p_mode_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CONV |=> st_q != ST_SPLIT && st_q != ST_MSG);
endmodule

// File: rtl/rd_abort_ctrl.sv
module rd_abort_ctrl
  import rd_abort_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  input  logic              mode_i,
  input  logic              ecc_ta_en_i,
  input  logic              ta_mask_i,
  input  logic              scem_mask_i,
  input  logic              ret_valid_i,
  output logic              ret_ready_o,
  input  logic [1:0]        ret_abort_i,
  input  logic [DATA_W-1:0] ret_data_i,
  input  logic              host_req_i,
  output logic              host_ack_o,
  output logic              host_ta_o,
  output logic              host_disc_o,
  output logic [DATA_W/2-1:0] host_data_o,
  input  logic              cyc_done_i,
  output logic              scem_valid_o,
  input  logic              scem_ready_i,
  output logic [3:0]        scem_class_o,
  output logic [7:0]        scem_index_o,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [ISR_W-1:0]  isr_o
);
  logic q_push, q_push_abort, q_pop, q_flush, q_empty, q_full, q_head_abort;
  logic [DATA_W-1:0] q_head_data;
  logic set_ta, set_scem;

  rd_qword_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk_i, .rst_ni,
    .push_i(q_push), .push_abort_i(q_push_abort), .push_data_i(ret_data_i),
    .pop_i(q_pop), .flush_i(q_flush),
    .empty_o(q_empty), .full_o(q_full),
    .head_abort_o(q_head_abort), .head_data_o(q_head_data)
  );

  abort_resp_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .rd_start_i, .mode_i, .ta_en_i(ecc_ta_en_i),
    .ret_valid_i, .ret_abort_i, .host_req_i, .cyc_done_i, .scem_ready_i,
    .q_empty_i(q_empty), .q_full_i(q_full),
    .q_head_abort_i(q_head_abort), .q_head_data_i(q_head_data),
    .ret_ready_o, .q_push_o(q_push), .q_push_abort_o(q_push_abort),
    .q_pop_o(q_pop), .q_flush_o(q_flush),
    .host_ack_o, .host_ta_o, .host_disc_o, .host_data_o, .scem_valid_o,
    .set_ta_o(set_ta), .set_scem_o(set_scem)
  );

  abort_stat_regs u_regs (
    .clk_i, .rst_ni, .set_ta_i(set_ta), .set_scem_i(set_scem),
    .ta_mask_i, .scem_mask_i, .reg_wr_i, .reg_sel_i, .reg_wdata_i,
    .status_o, .isr_o
  );

  assign scem_class_o = scem_valid_o ? SCEM_CLASS : '0;
  assign scem_index_o = scem_valid_o ? SCEM_INDEX : '0;

  p_msg_fields_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scem_valid_o && !scem_ready_i |=> $stable(scem_class_o) && $stable(scem_index_o));
  p_ta_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ta_o |-> status_o[TA_STS_BIT]);
endmodule

// File: tb/rd_abort_ctrl_test.sv
module rd_abort_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_start = 0, mode = 0, ta_en = 0, ta_mask = 0, sc_mask = 0;
  logic ret_valid = 0, ret_ready;
  logic [1:0] ret_abort = 0;
  logic [63:0] ret_data = 0;
  logic host_req = 0, host_ack, host_ta, host_disc;
  logic [31:0] host_data;
  logic cyc_done = 0, sc_valid, sc_ready = 0;
  logic [3:0] sc_class;
  logic [7:0] sc_index;
  logic reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] status;
  logic [7:0] isr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rd_abort_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_start_i(rd_start), .mode_i(mode),
    .ecc_ta_en_i(ta_en), .ta_mask_i(ta_mask), .scem_mask_i(sc_mask),
    .ret_valid_i(ret_valid), .ret_ready_o(ret_ready), .ret_abort_i(ret_abort),
    .ret_data_i(ret_data), .host_req_i(host_req), .host_ack_o(host_ack),
    .host_ta_o(host_ta), .host_disc_o(host_disc), .host_data_o(host_data),
    .cyc_done_i(cyc_done), .scem_valid_o(sc_valid), .scem_ready_i(sc_ready),
    .scem_class_o(sc_class), .scem_index_o(sc_index), .reg_wr_i(reg_wr),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .status_o(status), .isr_o(isr)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  function automatic logic [63:0] qw(input int p);
    return {32'hB000_0000 + 32'(2*p+1), 32'hA000_0000 + 32'(2*p)};
  endfunction

  task automatic start_rd(input logic m);
    mode = m; rd_start = 1; tick; rd_start = 0;
  endtask

  task automatic push(input logic [63:0] d, input logic [1:0] ab);
    chk(ret_ready, 1, "R4 ready");
    ret_valid = 1; ret_data = d; ret_abort = ab; tick;
    ret_valid = 0; ret_abort = 0;
  endtask

  task automatic hread(output logic a, output logic t, output logic dc, output logic [31:0] d);
    host_req = 1; tick; host_req = 0;
    a = host_ack; t = host_ta; dc = host_disc; d = host_data;
  endtask

  task automatic done; cyc_done = 1; tick; cyc_done = 0; endtask

  task automatic w1c(input logic sel, input logic [15:0] v);
    reg_wr = 1; reg_sel = sel; reg_wdata = v; tick; reg_wr = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a, t, dc;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({host_ack, host_ta, host_disc, sc_valid}, 0, "R12 outputs");
    chk(status, 0, "R12 status");
    chk(isr, 0, "R12 isr");
    rst_n = 1; tick;

    // conventional sweep
    for (int en = 0; en < 2; en++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 3; p++)
          for (int h = 1; h < 4; h++) begin
            ta_en = en[0]; ta_mask = m[0];
            start_rd(1'b0);
            for (int q = 0; q < 3; q++) push(qw(q), (q == p) ? h[1:0] : 2'b00);
            chk(status[11], 0, "R4 no early status");
            chk(isr, 0, "R4 no early isr");
            for (int w = 0; w < 2*p; w++) begin
              hread(a, t, dc, d);
              chk({a, t, dc}, 3'b100, "R4 clean ack");
              chk(d, (w % 2) ? qw(w/2)[63:32] : qw(w/2)[31:0], "R4 dword order");
            end
            hread(a, t, dc, d);  // R1: low dword of aborted qword hits abort for any h
            if (en == 1) chk({a, t, dc}, 3'b010, "R2 target abort");
            else begin
              chk({a, t, dc}, 3'b101, "R3 disconnect with data");
              chk(d, qw(p)[31:0], "R3 disconnect data");
            end
            chk(status[11], en, "R6 status bit 11");
            chk(isr[0], (en == 1 && m == 0), "R7 isr masked");
            hread(a, t, dc, d);
            chk({a, t, dc}, 0, "R5 silent after abort");
            done();
            start_rd(1'b0);
            hread(a, t, dc, d);
            chk({a, t, dc}, 0, "R5 flushed queue");
            done();
            w1c(1'b0, 16'h0800);
            w1c(1'b1, 16'h0003);
            chk({status, isr}, 0, "R10 w1c");
          end

    // split sweep
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 3; p++) begin
        sc_mask = m[0];
        start_rd(1'b1);
        for (int q = 0; q < p; q++) push(qw(q), 2'b00);
        for (int w = 0; w < 2*p; w++) begin
          hread(a, t, dc, d);
          chk(d, (w % 2) ? qw(w/2)[63:32] : qw(w/2)[31:0], "R4 split data");
        end
        push(qw(p), 2'b01);
        chk(sc_valid, 1, "R8 msg valid");
        chk({sc_class, sc_index}, 12'h281, "R8 class index");
        chk(isr[1], (m == 0), "R9 isr masked");
        chk(status[11], 0, "R6 no status in split");
        tick; tick;
        chk({sc_valid, sc_class, sc_index}, 13'h1281, "R8 held");
        sc_ready = 1; tick; sc_ready = 0;
        chk(sc_valid, 0, "R8 accepted");
        start_rd(1'b1);
        hread(a, t, dc, d);
        chk(a, 0, "R8 flushed");
        done();
        w1c(1'b1, 16'h0002);
        chk(isr, 0, "R10 isr clear");
      end

    // R11: mode change mid transaction ignored
    ta_en = 1; ta_mask = 0;
    start_rd(1'b0);
    mode = 1;
    push(qw(0), 2'b10);
    chk(sc_valid, 0, "R11 no msg");
    hread(a, t, dc, d);
    chk(t, 1, "R11 conventional abort kept");
    done();
    mode = 0;

    // R10: set wins over same-cycle clear
    w1c(1'b0, 16'h0800);
    start_rd(1'b0);
    push(qw(1), 2'b11);
    host_req = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0800;
    tick;
    host_req = 0; reg_wr = 0;
    chk(host_ta, 1, "R2 abort");
    chk(status[11], 1, "R10 set priority");
    done();
    w1c(1'b0, 16'h0800);
    chk(status[11], 0, "R10 clear after");

    finish_run();
  end
endmodule